// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns parallel pixel slices into serial bit streams for a flat-panel display link. Each data lane takes one 7-bit slice per pixel period and sends it most significant bit first. One more lane carries the forwarded link clock. That clock is not a divided clock: it is the 7-bit waveform 1100011, repeated once per pixel period and kept bit-aligned with the data frames.

Everything runs from one fast bit clock. The block keeps a bit-position counter and raises a one-cycle `ready` pulse whenever the upstream source must supply the next parallel word. The word on `pix_in` is captured at the clock edge that ends the pulse.

A parameter selects the output rate:

- **Single-data-rate build:** one bit per lane leaves per fast-clock cycle.
- **Double-data-rate build:** two bits per lane leave per cycle, meant for an output stage that sends one bit on each clock edge. A 7-bit frame then lasts 3.5 cycles, so the pixel period alternates between 3 and 4 fast cycles. The serial stream is the same as the single-data-rate stream at twice the clock.

Top module: `pixel_link_ser`

## Requirements
- R1: Each data lane l sends the slice `pix_in[7l+6:7l]` of every captured word as one 7-bit frame, bit 6 first and bit 0 last. Frames follow each other with no gap, in capture order. A word captured at a `ready` pulse is sent in the frame right after the frame that is in progress at that pulse.
- R2: The clock lane (the highest lane) repeats the 7-bit pattern 1, 1, 0, 0, 0, 1, 1 without a break. The first bit of the pattern lines up with the first bit of every data frame on every lane.
- R3: With DDR=0, every lane sends one bit per cycle on `ser_out[l]`. `ready` pulses exactly once every 7 cycles.
- R4: With DDR=1, every lane sends two bits per cycle on `ser_out[2l+1:2l]`, with bit 2l+1 earlier in the stream than bit 2l. The spacing between `ready` pulses alternates between 3 and 4 cycles, and the first interval after reset is 3 cycles.
- R5: `ready` is high for a single cycle at a time. The block captures `pix_in` at the rising edge that ends the high cycle.
- R6: While `rst` is high at a rising edge, all output bits go low, `ready` stays low, and the bit position returns to the start of a frame.
- R7: After `rst` is released, `ready` is high in the first cycle. The first frame carries all-zero data, and the clock lane begins with the first bit of its pattern.
- R8: The serial stream on each lane is the same in both builds for the same sequence of words, including the reset behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 7*LANES | Parallel word, one 7-bit slice per data lane; lane l at bits 7l+6..7l |
| ready | output | 1 | One-cycle request for the next word; `pix_in` is captured at the end of this cycle |
| ser_out | output | (LANES+1)*NB | Serial bits: NB bits per lane, data lanes first and the clock lane last; NB is 1 in the single-data-rate build and 2 in the double-data-rate build, with the higher bit of a pair sent first |

## Verification
The bench builds two copies with four data lanes: one with DDR=0 and one with DDR=1. Both are fed the same word sequence and checked against one shared bit-stream model. Running both builds puts the even 7-cycle load spacing and the alternating 3/4-cycle spacing within reach, including the frame that ends mid-cycle and splits across a bit pair. The word sequence opens with all-zero, all-one and alternating slices, then random words. A second reset in the middle of the run repeats the start-up frame and the clock-lane phase in both builds.

// File: rtl/pixel_link_ser.sv
module pixel_link_ser #(
  parameter int LANES = 4,
  parameter bit DDR = 1'b0,
  localparam int NB = DDR ? 2 : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7*LANES-1:0]      pix_in,
  output logic                    ready,
  output logic [(LANES+1)*NB-1:0] ser_out
);
  localparam int SPAN = 14;
  localparam int SPLIT = DDR ? 6 : 7;
  localparam logic [SPAN-1:0] CLKPAT = 14'b1100011_1100011;

  logic [3:0] pos;
  logic [SPAN-1:0] frm [LANES];
  logic [(LANES+1)*NB-1:0] nxt;

  wire at_a = (pos == 4'd0);
  wire at_b = (pos == 4'(SPLIT));

  assign ready = !rst && (at_a || at_b);

  always_comb begin
    for (int l = 0; l < LANES; l++)
      for (int j = 0; j < NB; j++)
        nxt[l*NB + NB-1-j] = frm[l][4'(SPAN-1 - int'(pos) - j)];
    for (int j = 0; j < NB; j++)
      nxt[LANES*NB + NB-1-j] = CLKPAT[4'(SPAN-1 - int'(pos) - j)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      ser_out <= '0;
      for (int l = 0; l < LANES; l++) frm[l] <= '0;
    end else begin
      ser_out <= nxt;
      for (int l = 0; l < LANES; l++) begin
        if (at_a) frm[l][6:0] <= pix_in[l*7 +: 7];
        if (at_b) frm[l][13:7] <= pix_in[l*7 +: 7];
      end
      pos <= (int'(pos) + NB >= SPAN) ? 4'd0 : pos + 4'(NB);
    end
  end
endmodule

module pixel_link_chk #(
  parameter int LANES = 4,
  parameter bit DDR = 1'b0,
  localparam int NB = DDR ? 2 : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ready,
  input logic [(LANES+1)*NB-1:0] ser_out
);
  logic [3:0] gap, lastgap, age;
  logic [1:0] seen;
  wire [NB-1:0] clk_lane = ser_out[LANES*NB +: NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; lastgap <= '0; seen <= '0; age <= '0;
    end else begin
      if (age != 4'hf) age <= age + 4'd1;
      if (ready) begin
        gap <= 4'd1;
        lastgap <= gap;
        if (seen != 2'd3) seen <= seen + 2'd1;
      end else if (gap != 4'hf) gap <= gap + 4'd1;
    end
  end

  p_reset_low_r6: assert property (@(posedge clk) rst |=> ser_out == '0);
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (rst) ready |=> !ready);
  p_clk_period_r2: assert property (@(posedge clk) disable iff (rst)
    (age >= 4'd8) |-> clk_lane == $past(clk_lane, 7));

  if (DDR) begin : g_ddr
    p_ready_gap_ddr_r4: assert property (@(posedge clk) disable iff (rst)
      (ready && seen != 2'd0) |-> (gap == 4'd3 || gap == 4'd4));
    p_ready_alt_ddr_r4: assert property (@(posedge clk) disable iff (rst)
      (ready && seen >= 2'd2) |-> gap != lastgap);
  end else begin : g_sdr
    p_ready_gap_sdr_r3: assert property (@(posedge clk) disable iff (rst)
      (ready && seen != 2'd0) |-> gap == 4'd7);
  end
endmodule

bind pixel_link_ser pixel_link_chk #(.LANES(LANES), .DDR(DDR)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .ser_out(ser_out)
);

// File: tb/sim_pixel_link_ser.sv
module sim_pixel_link_ser;
  localparam int LANES = 4;
  localparam int NW = 700;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7*LANES-1:0] pix0 = '0, pix1 = '0;
  logic rdy0, rdy1;
  logic [LANES:0] so0;
  logic [2*LANES+1:0] so1;

  always #4 clk = ~clk;

  pixel_link_ser #(.LANES(LANES), .DDR(1'b0)) u0 (.clk(clk), .rst(rst), .pix_in(pix0), .ready(rdy0), .ser_out(so0));
  pixel_link_ser #(.LANES(LANES), .DDR(1'b1)) u1 (.clk(clk), .rst(rst), .pix_in(pix1), .ready(rdy1), .ser_out(so1));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7*LANES-1:0] words [NW];
  bit q [2][LANES][$];
  int widx [2];
  int cp [2];
  int cyc, lastr [2], expgap [2];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic restart();
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < LANES; l++) begin
        q[m][l].delete();
        for (int b = 0; b < 7; b++) q[m][l].push_back(1'b0);
      end
      cp[m] = 0; lastr[m] = -1; expgap[m] = m ? 3 : 7;
    end
  endtask

  task automatic serve(int m);
    bit r = m ? rdy1 : rdy0;
    if (!r) return;
    if (lastr[m] >= 0) begin
      chk(cyc - lastr[m] == expgap[m], m ? "R4 ready spacing" : "R3 ready spacing", cyc - lastr[m], expgap[m]);
      if (m) expgap[m] = (expgap[m] == 3) ? 4 : 3;
    end
    lastr[m] = cyc;
    if (m) pix1 = words[widx[m] % NW]; else pix0 = words[widx[m] % NW];
    for (int l = 0; l < LANES; l++)
      for (int b = 6; b >= 0; b--) q[m][l].push_back(words[widx[m] % NW][l*7 + b]);
    widx[m]++;
  endtask

  task automatic compare(int m);
    int nb = m ? 2 : 1;
    int act, expv;
    for (int l = 0; l < LANES; l++) begin
      act = 0; expv = 0;
      for (int j = 0; j < nb; j++) begin
        act = (act << 1) | int'(m ? so1[l*2 + 1 - j] : so0[l]);
        expv = (expv << 1) | int'(q[m][l].size() > 0 ? q[m][l].pop_front() : 1'b0);
      end
      chk(act == expv, m ? "R1/R4/R8 data lane ddr" : "R1/R3/R8 data lane sdr", act, expv);
    end
    act = 0; expv = 0;
    for (int j = 0; j < nb; j++) begin
      act = (act << 1) | int'(m ? so1[LANES*2 + 1 - j] : so0[LANES]);
      expv = (expv << 1) | int'(PAT[6 - cp[m]]);
      cp[m] = (cp[m] + 1) % 7;
    end
    chk(act == expv, "R2 clock lane", act, expv);
  endtask

  task automatic run_reset(int n);
    rst = 1'b1;
    repeat (n) begin
      @(negedge clk); #1;
      chk(so0 == '0 && so1 == '0, "R6 outputs low in reset", int'({so1, so0}), 0);
      chk(!rdy0 && !rdy1, "R6 ready low in reset", int'({rdy1, rdy0}), 0);
    end
    @(negedge clk);
    rst = 1'b0; #1;
    restart();
    cyc = 0;
    chk(rdy0 && rdy1, "R7 ready in first cycle", int'({rdy1, rdy0}), 3);
    serve(0); serve(1);
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #1;
      cyc++;
      compare(0); compare(1);
      chk(!(rdy0 && lastr[0] == cyc - 1), "R5 ready single cycle", 1, 0);
      serve(0); serve(1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    words[0] = '1;
    words[1] = '0;
    words[2] = {LANES{7'b1010101}};
    words[3] = {LANES{7'b0101010}};
    words[4] = {LANES{7'b1000000}};
    words[5] = {LANES{7'b0000001}};
    for (int i = 6; i < NW; i++) words[i] = 28'($urandom());
    widx[0] = 0; widx[1] = 0;
    run_reset(4);
    run(1200);
    run_reset(3);
    run(600);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule